// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C master. Software writes a period value and a command that asks for a START condition, a byte transfer and a STOP condition, in any combination. The block turns that command into a sequence of clock slots. Each slot has a pulled-low phase and a released phase, and each is timed from the period value in system clocks.

SCL is an open-drain line. After releasing it, the block waits until the synchronized line actually reads high before it begins counting the high phase. A slow rising edge, or a target device that holds the line low, therefore lengthens the period instead of shortening the high time. In high-speed mode every slot after the first (the preamble) drives SCL high as well as low, so the period is exactly the programmed one.

A command is taken in and then launched after a fixed pipeline latency, so BUSY appears a few clocks after the write. At the end of the transaction BUSY falls and a one-cycle done pulse is given, which can serve as an interrupt. Per-slot strobes, the slot kind and the bit index let a separate byte engine move SDA at the right moments.

Top module: `i2c_scl_timer`

## Requirements
- R1: While and after reset, busy, done, scl_pull_low, scl_drive_high, bit_low_stb and bit_high_stb are 0 and slot_kind is 0.
- R2: cmd_bits encodes bit 0 = START, bit 1 = RUN, bit 2 = STOP. A write with cmd_wr high and all three bits 0 is ignored: busy stays low and SCL is unchanged.
- R3: For an accepted command, busy is still low for the first LAUNCH_LAT-1 clocks after the accepting edge and goes high at the LAUNCH_LAT-th edge (4 by default).
- R4: Slots run in this order: a START slot if bit 0 is set, then BYTE_BITS data slots with bit_idx 0 to BYTE_BITS-1 if bit 1 is set, then a STOP slot if bit 2 is set. slot_kind reads 1 for START, 2 for data, 3 for STOP and 0 when idle. bit_idx is 0 outside data slots.
- R5: In each slot SCL is pulled low for 12*(tpr+1) clocks and then released. The high phase lasts 8*(tpr+1) clocks counted on the synchronized line.
- R6: SCL is read through a two-flop synchronizer. The high count starts only once the synchronized line is high, and restarts if the line is seen low during the count. With the line rising d clocks after release and no holding, the slot period is 20*(tpr+1)+3+d clocks.
- R7: hs_mode is taken with the command. In high-speed mode the first slot behaves as in R5 and R6. Every later slot asserts scl_drive_high for its whole high phase, does not wait for the line, and has a period of exactly 20*(tpr+1) clocks. scl_drive_high is never high together with scl_pull_low, nor outside high-speed mode.
- R8: bit_low_stb is high for the first clock of each data slot's low phase. bit_high_stb is high for the first clock of each data slot's high count, including a count that restarts.
- R9: On the edge after the last clock of the final slot's high phase, busy falls and done is high for exactly one clock.
- R10: A command write while busy is high, or while an accepted command is still in its launch latency, is ignored.
- R11: If a transaction ends without a STOP slot, SCL stays pulled low until the next transaction launches. After a STOP it is released.
- R12: tpr and hs_mode are sampled when the command is accepted. Later changes do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tpr | input | TPR_W | Timer period value; one slot unit is tpr+1 clocks |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 3 | bit 0 START, bit 1 RUN, bit 2 STOP |
| hs_mode | input | 1 | High-speed mode select, taken with the command |
| scl_in | input | 1 | Raw SCL line level |
| scl_pull_low | output | 1 | Pull SCL low |
| scl_drive_high | output | 1 | Actively drive SCL high (high-speed mode) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| bit_low_stb | output | 1 | First clock of a data slot's low phase |
| bit_high_stb | output | 1 | First clock of a data slot's high count |
| slot_kind | output | 2 | 0 idle, 1 START, 2 data, 3 STOP |
| bit_idx | output | $clog2(BYTE_BITS) | Index of the current data slot |

## Verification
The bench builds the block with TPR_W=4, LAUNCH_LAT=4 and BYTE_BITS=9, and drives tpr values of 1, 2 and 4. This keeps a full START-byte-STOP transaction near a thousand clocks, so several transactions fit in one run, including ones with a rise delay, a target holding the line mid high phase, and high-speed mode. The bench models the open-drain line itself: a programmable rise delay after release and a hold input. This lets the stretching arithmetic (20*(tpr+1)+3+d) and the restart of the high count be measured directly at the strobes.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    localparam int LOW_UNITS  = 12;
    localparam int HIGH_UNITS = 8;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_START = 2'd1,
        SLOT_DATA  = 2'd2,
        SLOT_STOP  = 2'd3
    } slot_e;

    typedef struct packed {
        logic stop;
        logic run;
        logic start;
    } cmd_t;

    function automatic slot_e opening_slot(cmd_t c);
        if (c.start) return SLOT_START;
        if (c.run)   return SLOT_DATA;
        return SLOT_STOP;
    endfunction

    function automatic logic cmd_empty(cmd_t c);
        return !(c.start || c.run || c.stop);
    endfunction

endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/i2c_scl_launch.sv
module i2c_scl_launch
    import i2c_scl_pkg::*;
#(
    parameter int TPR_W = 7,
    parameter int LAT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  cmd_t             cmd_in,
    input  logic             hs_in,
    input  logic [TPR_W-1:0] tpr_in,
    input  logic             busy,
    output logic             launch,
    output logic             pending,
    output cmd_t             cmd_q,
    output logic             hs_q,
    output logic [TPR_W-1:0] tpr_q
);
    logic           accept;
    logic [LAT-1:0] pipe;

    assign pending = |pipe;
    assign launch  = pipe[LAT-1];
    assign accept  = cmd_wr && !busy && !pending && !cmd_empty(cmd_in);

    generate
        if (LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= accept;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[LAT-2:0], accept};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            hs_q  <= 1'b0;
            tpr_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
            hs_q  <= hs_in;
            tpr_q <= tpr_in;
        end
    end

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (busy || pending)) |=> ($stable(cmd_q) && $stable(hs_q) && $stable(tpr_q))); // R10
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pipe)); // R10
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
    import i2c_scl_pkg::*;
#(
    parameter int TPR_W     = 7,
    parameter int BYTE_BITS = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         launch,
    input  cmd_t                         cmd,
    input  logic                         hs,
    input  logic [TPR_W-1:0]             tpr,
    input  logic                         scl_hi,
    output logic                         scl_pull_low,
    output logic                         scl_drive_high,
    output logic                         busy,
    output logic                         done,
    output logic                         bit_low_stb,
    output logic                         bit_high_stb,
    output slot_e                        kind,
    output logic [$clog2(BYTE_BITS)-1:0] idx
);
    localparam int CNT_W = TPR_W + 4;
    localparam int IDX_W = $clog2(BYTE_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_BITS - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             first;
    logic             hold;
    logic [CNT_W-1:0] unit, low_len, high_len;
    logic             hs_now;
    slot_e            nxt_kind;
    logic [IDX_W-1:0] nxt_idx;

    assign unit     = CNT_W'(tpr) + CNT_W'(1);
    assign low_len  = unit * CNT_W'(LOW_UNITS);
    assign high_len = unit * CNT_W'(HIGH_UNITS);
    assign hs_now   = hs && !first;

    always_comb begin
        nxt_kind = SLOT_NONE;
        nxt_idx  = '0;
        unique case (kind)
            SLOT_START: begin
                if (cmd.run)       nxt_kind = SLOT_DATA;
                else if (cmd.stop) nxt_kind = SLOT_STOP;
            end
            SLOT_DATA: begin
                if (idx != LAST_IDX) begin
                    nxt_kind = SLOT_DATA;
                    nxt_idx  = idx + IDX_W'(1);
                end else if (cmd.stop) begin
                    nxt_kind = SLOT_STOP;
                end
            end
            default: nxt_kind = SLOT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            kind  <= SLOT_NONE;
            idx   <= '0;
            cnt   <= '0;
            first <= 1'b0;
            hold  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (launch) begin
                    phase <= PH_LOW;
                    kind  <= opening_slot(cmd);
                    idx   <= '0;
                    cnt   <= low_len - CNT_W'(1);
                    first <= 1'b1;
                    hold  <= 1'b0;
                    busy  <= 1'b1;
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        if (hs_now) begin
                            phase <= PH_HIGH;
                            cnt   <= high_len - CNT_W'(1);
                        end else begin
                            phase <= PH_WAIT_HI;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_WAIT_HI: if (scl_hi) begin
                    phase <= PH_HIGH;
                    cnt   <= high_len - CNT_W'(1);
                end
                PH_HIGH: begin
                    if (!hs_now && !scl_hi) begin
                        phase <= PH_WAIT_HI;
                    end else if (cnt == '0) begin
                        first <= 1'b0;
                        if (nxt_kind != SLOT_NONE) begin
                            phase <= PH_LOW;
                            kind  <= nxt_kind;
                            idx   <= nxt_idx;
                            cnt   <= low_len - CNT_W'(1);
                        end else begin
                            phase <= PH_IDLE;
                            kind  <= SLOT_NONE;
                            idx   <= '0;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            hold  <= (kind != SLOT_STOP);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign scl_pull_low   = (phase == PH_LOW) || (phase == PH_IDLE && hold);
    assign scl_drive_high = hs_now && (phase == PH_HIGH);
    assign bit_low_stb    = (phase == PH_LOW) && (cnt == low_len - CNT_W'(1)) && (kind == SLOT_DATA);
    assign bit_high_stb   = (phase == PH_HIGH) && (cnt == high_len - CNT_W'(1)) && (kind == SLOT_DATA);

    AST_PULL_OR_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(scl_pull_low && scl_drive_high)); // R7
    AST_DRIVE_ONLY_HS: assert property (@(posedge clk) disable iff (rst)
        scl_drive_high |-> hs); // R7
    AST_HIGH_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && $past(phase) == PH_WAIT_HI) |-> $past(scl_hi)); // R6
    AST_BUSY_FROM_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch)); // R3
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R9
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int TPR_W      = 7,
    parameter int LAUNCH_LAT = 4,
    parameter int BYTE_BITS  = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TPR_W-1:0]             tpr,
    input  logic                         cmd_wr,
    input  logic [2:0]                   cmd_bits,
    input  logic                         hs_mode,
    input  logic                         scl_in,
    output logic                         scl_pull_low,
    output logic                         scl_drive_high,
    output logic                         busy,
    output logic                         done,
    output logic                         bit_low_stb,
    output logic                         bit_high_stb,
    output logic [1:0]                   slot_kind,
    output logic [$clog2(BYTE_BITS)-1:0] bit_idx
);
    localparam int SYNC_STAGES = 2;

    logic             scl_hi, launch, pending, hs_q;
    cmd_t             cmd_q;
    logic [TPR_W-1:0] tpr_q;
    slot_e            kind;

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_hi)
    );

    i2c_scl_launch #(.TPR_W(TPR_W), .LAT(LAUNCH_LAT)) u_launch (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (cmd_wr),
        .cmd_in  (cmd_t'(cmd_bits)),
        .hs_in   (hs_mode),
        .tpr_in  (tpr),
        .busy    (busy),
        .launch  (launch),
        .pending (pending),
        .cmd_q   (cmd_q),
        .hs_q    (hs_q),
        .tpr_q   (tpr_q)
    );

    i2c_scl_phase #(.TPR_W(TPR_W), .BYTE_BITS(BYTE_BITS)) u_phase (
        .clk            (clk),
        .rst            (rst),
        .launch         (launch),
        .cmd            (cmd_q),
        .hs             (hs_q),
        .tpr            (tpr_q),
        .scl_hi         (scl_hi),
        .scl_pull_low   (scl_pull_low),
        .scl_drive_high (scl_drive_high),
        .busy           (busy),
        .done           (done),
        .bit_low_stb    (bit_low_stb),
        .bit_high_stb   (bit_high_stb),
        .kind           (kind),
        .idx            (bit_idx)
    );

    assign slot_kind = kind;
endmodule

// File: tb/sim_i2c_scl_timer.sv
`timescale 1ns/1ps
module sim_i2c_scl_timer;
    localparam int TPR_W = 4;
    localparam int LAT   = 4;
    localparam int BB    = 9;
    localparam int IW    = $clog2(BB);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TPR_W-1:0] tpr = '0;
    logic cmd_wr = 1'b0;
    logic [2:0] cmd_bits = '0;
    logic hs_mode = 1'b0;
    logic scl_in;
    logic scl_pull_low, scl_drive_high, busy, done, bit_low_stb, bit_high_stb;
    logic [1:0] slot_kind;
    logic [IW-1:0] bit_idx;

    int checks = 0, fails = 0, cyc = 0;
    int rel = 0, rise_dly = 0;
    logic slave_hold = 1'b0;
    bit cmp_en = 0, finished = 0;

    always #10 clk = ~clk;

    assign scl_in = !scl_pull_low && (scl_drive_high || ((rel >= rise_dly) && !slave_hold));

    i2c_scl_timer #(.TPR_W(TPR_W), .LAUNCH_LAT(LAT), .BYTE_BITS(BB)) u0 (
        .clk(clk), .rst(rst), .tpr(tpr), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
        .hs_mode(hs_mode), .scl_in(scl_in), .scl_pull_low(scl_pull_low),
        .scl_drive_high(scl_drive_high), .busy(busy), .done(done),
        .bit_low_stb(bit_low_stb), .bit_high_stb(bit_high_stb),
        .slot_kind(slot_kind), .bit_idx(bit_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (scl_pull_low) rel <= 0;
        else if (rel < 1000) rel <= rel + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phases 0 idle, 1 low, 2 wait for line, 3 high
    int m_wait, m_phase, m_rem, m_n, m_kind, m_idx;
    bit m_first, m_hs, m_hold, m_busy, m_done, q1, q2;
    int m_q[$];

    always @(posedge clk) begin
        bit line, acc, go;
        if (rst) begin
            m_wait = 0; m_phase = 0; m_rem = 0; m_n = 1; m_kind = 0; m_idx = 0;
            m_first = 0; m_hs = 0; m_hold = 0; m_busy = 0; m_done = 0;
            q1 = 1; q2 = 1; m_q.delete();
        end else begin
            line = q2;
            acc  = cmd_wr && !m_busy && (m_wait == 0) && (cmd_bits != 3'b000);
            go   = (m_wait == 1);
            if (m_wait > 0) m_wait--;
            m_done = 0;
            case (m_phase)
                0: if (go) begin
                    int e;
                    e = m_q.pop_front();
                    m_kind = e / 16; m_idx = e % 16;
                    m_phase = 1; m_rem = 12 * m_n; m_first = 1; m_hold = 0; m_busy = 1;
                end
                1: if (m_rem == 1) begin
                    if (m_hs && !m_first) begin m_phase = 3; m_rem = 8 * m_n; end
                    else m_phase = 2;
                end else m_rem--;
                2: if (line) begin m_phase = 3; m_rem = 8 * m_n; end
                default: begin
                    if (!(m_hs && !m_first) && !line) m_phase = 2;
                    else if (m_rem == 1) begin
                        m_first = 0;
                        if (m_q.size() > 0) begin
                            int e;
                            e = m_q.pop_front();
                            m_kind = e / 16; m_idx = e % 16;
                            m_phase = 1; m_rem = 12 * m_n;
                        end else begin
                            m_hold = (m_kind != 3);
                            m_phase = 0; m_kind = 0; m_idx = 0; m_busy = 0; m_done = 1;
                        end
                    end else m_rem--;
                end
            endcase
            if (acc) begin
                m_q.delete();
                if (cmd_bits[0]) m_q.push_back(16);
                if (cmd_bits[1]) for (int i = 0; i < BB; i++) m_q.push_back(32 + i);
                if (cmd_bits[2]) m_q.push_back(48);
                m_n = int'(tpr) + 1; m_hs = hs_mode; m_wait = LAT;
            end
            q2 = q1; q1 = scl_in;
        end
    end

    int n_low = 0, n_high = 0, n_drive = 0, last_low = -1;
    int ivals[$];

    always @(negedge clk) begin
        if (cmp_en) begin
            bit e_pull, e_drive, e_ls, e_hs;
            e_pull  = (m_phase == 1) || (m_phase == 0 && m_hold);
            e_drive = (m_phase == 3) && m_hs && !m_first;
            e_ls    = (m_phase == 1) && (m_rem == 12 * m_n) && (m_kind == 2);
            e_hs    = (m_phase == 3) && (m_rem == 8 * m_n) && (m_kind == 2);
            chk(busy == m_busy, "R3 busy model", busy, m_busy);
            chk(done == m_done, "R9 done model", done, m_done);
            chk(scl_pull_low == e_pull, "R5 pull model", scl_pull_low, e_pull);
            chk(scl_drive_high == e_drive, "R7 drive model", scl_drive_high, e_drive);
            chk(bit_low_stb == e_ls, "R8 low strobe model", bit_low_stb, e_ls);
            chk(bit_high_stb == e_hs, "R8 high strobe model", bit_high_stb, e_hs);
            chk(int'(slot_kind) == m_kind, "R4 kind model", slot_kind, m_kind);
            chk(int'(bit_idx) == m_idx, "R4 idx model", bit_idx, m_idx);
        end
        if (bit_low_stb) begin
            if (last_low >= 0) ivals.push_back(cyc - last_low);
            last_low = cyc;
            n_low++;
        end
        if (bit_high_stb) n_high++;
        if (scl_drive_high) n_drive++;
    end

    task automatic clear_stats();
        n_low = 0; n_high = 0; n_drive = 0; last_low = -1; ivals.delete();
    endtask

    task automatic send(input logic [2:0] b, input logic hs);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_bits = b; hs_mode = hs;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_bits = '0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < 20000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic check_ivals(input string tag, input int exp);
        chk(ivals.size() == BB - 1, {tag, " interval count"}, ivals.size(), BB - 1);
        foreach (ivals[i]) chk(ivals[i] == exp, tag, ivals[i], exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1 busy at reset", busy, 0);
        chk(scl_pull_low == 0 && scl_drive_high == 0, "R1 scl at reset", scl_pull_low, 0);
        chk(done == 0 && slot_kind == 0, "R1 done/kind at reset", slot_kind, 0);
        rst = 1'b0;
        cmp_en = 1;
        repeat (2) @(negedge clk);

        // full transaction, tpr=4, fast rise
        tpr = 4'd4; rise_dly = 0; clear_stats();
        send(3'b111, 1'b0);
        chk(busy == 0, "R3 busy after accept edge", busy, 0);
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            chk(busy == 0, "R3 busy inside latency", busy, 0);
        end
        @(negedge clk);
        chk(busy == 1, "R3 busy at latency end", busy, 1);
        wait_done();
        check_ivals("R6 period rise 0", 20 * 5 + 3);
        chk(n_high == BB, "R8 high strobe count", n_high, BB);
        chk(busy == 0, "R9 busy after end", busy, 0);
        repeat (3) @(negedge clk);
        chk(scl_pull_low == 0, "R11 released after stop", scl_pull_low, 0);

        // run only, rise 2, ignored writes while pending and busy
        tpr = 4'd4; rise_dly = 2; clear_stats();
        send(3'b010, 1'b0);
        send(3'b111, 1'b0);
        repeat (300) @(negedge clk);
        send(3'b111, 1'b0);
        wait_done();
        check_ivals("R6 period rise 2", 20 * 5 + 3 + 2);
        repeat (10) @(negedge clk);
        chk(busy == 0, "R10 no relaunch", busy, 0);
        chk(n_low == BB, "R10 single transaction", n_low, BB);
        chk(scl_pull_low == 1, "R11 held low without stop", scl_pull_low, 1);

        // empty command
        send(3'b000, 1'b0);
        repeat (LAT + 4) @(negedge clk);
        chk(busy == 0, "R2 empty command ignored", busy, 0);
        chk(scl_pull_low == 1, "R2 empty command leaves scl", scl_pull_low, 1);

        // tpr changed after acceptance
        tpr = 4'd1; rise_dly = 0; clear_stats();
        send(3'b010, 1'b0);
        repeat (LAT) @(negedge clk);
        tpr = 4'd4;
        wait_done();
        check_ivals("R12 period uses accepted tpr", 20 * 2 + 3);

        // high-speed mode with slow rise
        tpr = 4'd2; rise_dly = 5; clear_stats();
        send(3'b111, 1'b1);
        wait_done();
        check_ivals("R7 hs period exact", 20 * 3);
        chk(n_drive > 0, "R7 drive high seen", n_drive, 1);
        repeat (3) @(negedge clk);
        chk(scl_pull_low == 0, "R11 released after hs stop", scl_pull_low, 0);

        // target holds the line in a high phase
        tpr = 4'd1; rise_dly = 0; hs_mode = 1'b0; clear_stats();
        send(3'b111, 1'b0);
        while (n_high < 3) @(negedge clk);
        repeat (3) @(negedge clk);
        slave_hold = 1'b1;
        repeat (20) @(negedge clk);
        slave_hold = 1'b0;
        wait_done();
        chk(n_high == BB + 1, "R6 high count restarted", n_high, BB + 1);
        chk(ivals.max()[0] > 43, "R6 stretched period", ivals.max()[0], 44);

        repeat (5) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end
endmodule